// File: doc/BRIEF.md
# Auxiliary Serial Port Master with Timed Busy Window

This block is a register-driven master for the auxiliary serial port of a cartridge slot. Software sees two registers: a control register (port enable, serial-mode select, chip-select hold, and a clock-rate code) and a one-byte data register. When the port is enabled and in serial mode, writing a byte to the data register starts a single-byte exchange with the attached slave. A busy flag in the control register stays high for a time set by the rate code. When that time runs out, the byte the slave returns replaces the data register and busy drops.

The transfer time is a base clock count, `BASE_FREQ`, shifted right by `SHIFT_TOP` minus the rate code. A down-counter is loaded with this value when a transfer starts. Writing the data register again while busy cancels the pending completion and reloads the counter.

The block also frames the slave's command state. The first byte completed after the framing is reopened is flagged as a command byte. All later bytes are flagged as payload. A control write in serial mode reopens the framing only if chip-select hold was off before that write. Chip select is asserted while a transfer is pending or while hold is on.

Top module: `aux_spi_master`

## Requirements
- R1: After reset, the control readback is 0, the data readback is 0, `slv_sel` is 0 and `slv_strobe` is 0.
- R2: A data write is accepted only when control bit 5 (enable) and bit 4 (serial mode) are both 1. Any other data write leaves the data readback unchanged and busy at 0.
- R3: In the cycle after an accepted data write, control readback bit 3 (busy) is 1.
- R4: Busy stays high for exactly `BASE_FREQ >> (SHIFT_TOP - code)` cycles, where `code` is control bits 1:0. With the bench parameters this is 8, 16, 32 or 64 cycles for codes 0 to 3.
- R5: An accepted data write while busy restarts the full duration from that write. The abandoned byte produces no exchange, and the exchange that does occur carries the newer byte.
- R6: Completion produces exactly one `slv_strobe` cycle, with `slv_tx` equal to the last accepted byte. In the next cycle, the data readback equals `slv_rx` as sampled in the strobe cycle, and busy is 0.
- R7: The first exchange after framing is reopened has `slv_cmd` = 1. Later exchanges have `slv_cmd` = 0 until framing is reopened again.
- R8: A control write with bit 4 = 1 reopens framing if the stored hold state was 0 before that write. If the stored hold state was 1, framing is kept.
- R9: Every control write with bit 4 = 1 copies bit 2 into the stored hold state. A control write with bit 4 = 0 leaves the hold state unchanged. `slv_sel` equals busy OR the stored hold state.
- R10: Control readback shows the written bits 5, 4, 2 and 1:0, the live busy state in bit 3, and 0 in bits 7:6. The value written to bit 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | BAUD_W+4 | Control write value |
| ctl_rdata | output | BAUD_W+4 (8 bits readback, padded) | Control readback including live busy |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | DATA_W | Byte to send |
| data_rdata | output | DATA_W | Data register readback |
| slv_sel | output | 1 | Chip select to slave (active high) |
| slv_strobe | output | 1 | One-cycle exchange pulse to slave |
| slv_cmd | output | 1 | Current exchange is the command byte |
| slv_tx | output | DATA_W | Byte presented to the slave |
| slv_rx | input | DATA_W | Byte returned by the slave, sampled on strobe |

## Verification
The bench builds the block with `BASE_FREQ` = 4194304, `SHIFT_TOP` = 19 and `BAUD_W` = 2. This makes every rate code yield a short whole-number duration (8 to 64 cycles), so each code's exact busy length can be measured at the ports. It keeps `USE_TABLE` = 1 so that the precomputed duration table is exercised. Because the windows are short, restarts at an exact mid-window cycle and long hold/reopen sequences on the command framing all fit in one run. Each of these is checked against strobe counts, `slv_cmd` and the data readback.

// File: rtl/aux_spi_pkg.sv
package aux_spi_pkg;

   // Transfer span for one rate code: base count shifted right by (top - code)
   function automatic longint unsigned span_for(input longint unsigned base,
                                                input int top,
                                                input int code);
      return base >> (top - code);
   endfunction

   // Control register field positions, derived from the rate-code width
   function automatic int pos_hold(input int bw);
      return bw;
   endfunction

   function automatic int pos_busy(input int bw);
      return bw + 1;
   endfunction

   function automatic int pos_mode(input int bw);
      return bw + 2;
   endfunction

   function automatic int pos_en(input int bw);
      return bw + 3;
   endfunction

endpackage

// File: rtl/aux_spi_ctl_regs.sv
module aux_spi_ctl_regs
   import aux_spi_pkg::*;
#(
   parameter int BAUD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [BAUD_W+3:0] ctl_wdata,
   input  logic              xfer_done,
   output logic [BAUD_W-1:0] rate_code,
   output logic              hold_field,
   output logic              mode_field,
   output logic              en_field,
   output logic              hold_state,
   output logic              frame_open
);

   localparam int P_HOLD = pos_hold(BAUD_W);
   localparam int P_MODE = pos_mode(BAUD_W);
   localparam int P_EN   = pos_en(BAUD_W);

   logic [BAUD_W-1:0] code_q;
   logic              hold_f_q;
   logic              mode_q;
   logic              en_q;
   logic              hold_q;
   logic              open_q;
   logic              mode_wr;
   logic              reopen;
   logic              wr_busy_unused;

   assign mode_wr        = ctl_wr && ctl_wdata[P_MODE];
   assign reopen         = mode_wr && !hold_q;
   assign wr_busy_unused = ctl_wdata[pos_busy(BAUD_W)];

   // Stored control fields; the busy position of the write value is discarded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         hold_f_q <= 1'b0;
         mode_q   <= 1'b0;
         en_q     <= 1'b0;
      end else if (ctl_wr) begin
         code_q   <= ctl_wdata[BAUD_W-1:0];
         hold_f_q <= ctl_wdata[P_HOLD];
         mode_q   <= ctl_wdata[P_MODE];
         en_q     <= ctl_wdata[P_EN];
      end
   end

   // Hold state follows the hold bit only on serial-mode control writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (mode_wr) begin
         hold_q <= ctl_wdata[P_HOLD];
      end
   end

   // Command framing: set after the first completed byte, cleared on reopen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (reopen) begin
         open_q <= 1'b0;
      end else if (xfer_done) begin
         open_q <= 1'b1;
      end
   end

   assign rate_code  = code_q;
   assign hold_field = hold_f_q;
   assign mode_field = mode_q;
   assign en_field   = en_q;
   assign hold_state = hold_q;
   assign frame_open = open_q;

   // R8: reopen clears framing
   assert_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reopen |=> !frame_open);

   // R8: with hold already on, framing survives a serial-mode control write
   assert_keep_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && hold_q && frame_open) |=> frame_open);

   // R9: non-serial control writes leave hold state alone
   assert_hold_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[P_MODE]) |=> (hold_state == $past(hold_state)));

   // R7: a completion without reopen closes the command slot
   assert_frame_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !reopen) |=> frame_open);

endmodule

// File: rtl/aux_spi_timer.sv
module aux_spi_timer
   import aux_spi_pkg::*;
#(
   parameter longint unsigned BASE_FREQ = 64'd33554432,
   parameter int              SHIFT_TOP = 19,
   parameter int              BAUD_W    = 2,
   parameter bit              USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BAUD_W-1:0] rate_code,
   output logic              busy,
   output logic              done
);

   localparam int              N_CODES  = 2 ** BAUD_W;
   localparam int              MAX_CODE = N_CODES - 1;
   localparam longint unsigned MAX_SPAN = span_for(BASE_FREQ, SHIFT_TOP, MAX_CODE);
   localparam longint unsigned MIN_SPAN = span_for(BASE_FREQ, SHIFT_TOP, 0);
   localparam int              CNT_W    = $clog2(MAX_SPAN + 1);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   // Elaboration checks on the parameter set
   if (BAUD_W < 1 || BAUD_W > 4) begin : g_bad_bw
      $error("aux_spi_timer: BAUD_W out of range");
   end
   if (SHIFT_TOP < MAX_CODE || SHIFT_TOP > 40) begin : g_bad_top
      $error("aux_spi_timer: SHIFT_TOP must cover every rate code");
   end
   if (MIN_SPAN < 1) begin : g_bad_base
      $error("aux_spi_timer: BASE_FREQ too small for the lowest rate code");
   end

   logic [CNT_W-1:0] span;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   generate
      if (USE_TABLE) begin : g_table
         // One precomputed duration per rate code
         logic [CNT_W-1:0] span_tab [N_CODES];
         for (genvar g = 0; g < N_CODES; g++) begin : g_entry
            localparam longint unsigned S = span_for(BASE_FREQ, SHIFT_TOP, g);
            assign span_tab[g] = CNT_W'(S);
         end
         assign span = span_tab[rate_code];
      end else begin : g_shift
         // Runtime shift of the longest span; exact because shifts compose
         localparam logic [CNT_W-1:0] TOP_V = CNT_W'(MAX_SPAN);
         logic [BAUD_W-1:0] back;
         assign back = BAUD_W'(MAX_CODE) - rate_code;
         assign span = TOP_V >> back;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= span;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == ONE) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == ONE) && !start;

   // R3: a start always leaves the block busy
   assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R4: counter loads the selected span
   assert_span_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == $past(span)));

   // R4: while busy the counter is never empty
   assert_no_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q != '0));

   // R6: completion is followed by an idle cycle
   assert_done_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

endmodule

// File: rtl/aux_spi_data.sv
module aux_spi_data #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done,
   input  logic [DATA_W-1:0] rx,
   output logic [DATA_W-1:0] q
);

   if (DATA_W < 1) begin : g_bad_dw
      $error("aux_spi_data: DATA_W must be positive");
   end

   logic [DATA_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (load) begin
         q_r <= wdata;
      end else if (done) begin
         q_r <= rx;
      end
   end

   assign q = q_r;

   // R6: received byte lands in the data register
   assert_rx_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> (q == $past(rx)));

   // R5: an accepted write is what the register holds next
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(wdata)));

endmodule

// File: rtl/aux_spi_master.sv
module aux_spi_master
   import aux_spi_pkg::*;
#(
   parameter longint unsigned BASE_FREQ = 64'd33554432,
   parameter int              SHIFT_TOP = 19,
   parameter int              BAUD_W    = 2,
   parameter int              DATA_W    = 8,
   parameter bit              USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [BAUD_W+3:0] ctl_wdata,
   output logic [BAUD_W+3:0] ctl_rdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [DATA_W-1:0] data_rdata,
   output logic              slv_sel,
   output logic              slv_strobe,
   output logic              slv_cmd,
   output logic [DATA_W-1:0] slv_tx,
   input  logic [DATA_W-1:0] slv_rx
);

   logic [BAUD_W-1:0] rate_code;
   logic              hold_field;
   logic              mode_field;
   logic              en_field;
   logic              hold_state;
   logic              frame_open;
   logic              busy;
   logic              done;
   logic              accept;
   logic [DATA_W-1:0] data_q;

   assign accept = data_wr && en_field && mode_field;

   aux_spi_ctl_regs #(
      .BAUD_W (BAUD_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .xfer_done  (done),
      .rate_code  (rate_code),
      .hold_field (hold_field),
      .mode_field (mode_field),
      .en_field   (en_field),
      .hold_state (hold_state),
      .frame_open (frame_open)
   );

   aux_spi_timer #(
      .BASE_FREQ (BASE_FREQ),
      .SHIFT_TOP (SHIFT_TOP),
      .BAUD_W    (BAUD_W),
      .USE_TABLE (USE_TABLE)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .rate_code (rate_code),
      .busy      (busy),
      .done      (done)
   );

   aux_spi_data #(
      .DATA_W (DATA_W)
   ) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .wdata (data_wdata),
      .done  (done),
      .rx    (slv_rx),
      .q     (data_q)
   );

   // Control readback: rate code, hold bit, live busy, mode, enable
   always_comb begin
      ctl_rdata                       = '0;
      ctl_rdata[BAUD_W-1:0]           = rate_code;
      ctl_rdata[pos_hold(BAUD_W)]     = hold_field;
      ctl_rdata[pos_busy(BAUD_W)]     = busy;
      ctl_rdata[pos_mode(BAUD_W)]     = mode_field;
      ctl_rdata[pos_en(BAUD_W)]       = en_field;
   end

   assign data_rdata = data_q;
   assign slv_sel    = busy || hold_state;
   assign slv_strobe = done;
   assign slv_cmd    = !frame_open;
   assign slv_tx     = data_q;

   // R2: a refused data write neither starts a transfer nor changes data
   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !(en_field && mode_field) && !busy) |=>
         (!busy && data_rdata == $past(data_rdata)));

   // R9: chip select is high whenever a transfer is pending
   assert_sel_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> slv_sel);

   // R5: a restart keeps the port busy
   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && busy) |=> (busy && !slv_strobe));

endmodule

// File: tb/aux_spi_master_test.sv
module aux_spi_master_test;

   localparam int BW = 2;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [BW+3:0] ctl_wdata = '0;
   logic [BW+3:0] ctl_rdata;
   logic          data_wr = 1'b0;
   logic [DW-1:0] data_wdata = '0;
   logic [DW-1:0] data_rdata;
   logic          slv_sel;
   logic          slv_strobe;
   logic          slv_cmd;
   logic [DW-1:0] slv_tx;
   logic [DW-1:0] slv_rx = '0;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   aux_spi_master #(
      .BASE_FREQ (64'd4194304),
      .SHIFT_TOP (19),
      .BAUD_W    (BW),
      .DATA_W    (DW),
      .USE_TABLE (1'b1)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .ctl_rdata  (ctl_rdata),
      .data_wr    (data_wr),
      .data_wdata (data_wdata),
      .data_rdata (data_rdata),
      .slv_sel    (slv_sel),
      .slv_strobe (slv_strobe),
      .slv_cmd    (slv_cmd),
      .slv_tx     (slv_tx),
      .slv_rx     (slv_rx)
   );

   // Control layout: [1:0] rate code, 2 hold, 3 busy, 4 mode, 5 enable
   localparam logic [5:0] EN   = 6'h20;
   localparam logic [5:0] MODE = 6'h10;
   localparam logic [5:0] HOLD = 6'h04;
   localparam logic [5:0] BUSY = 6'h08;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [5:0] v);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      @(negedge clk);
      data_wr = 1'b1; data_wdata = v;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   // One exchange; optional second write after 'late' busy cycles (0 = none)
   task automatic xfer(input logic [7:0] tx, input logic [7:0] tx2, input int late,
                       input logic [7:0] rx, input int exp_len, input bit exp_cmd,
                       input string tag);
      int n = 0;
      int strobes = 0;
      logic [7:0] seen_tx = '0;
      bit seen_cmd = 1'b0;
      slv_rx = rx;
      wr_data(tx);
      chk(ctl_rdata[3] == 1'b1, {tag, " R3 busy after write"}, ctl_rdata[3], 1);
      while (ctl_rdata[3] && n < 1000) begin
         if (slv_strobe) begin
            strobes++; seen_tx = slv_tx; seen_cmd = slv_cmd;
         end
         if (late != 0 && n == late) begin
            data_wr = 1'b1; data_wdata = tx2;
         end else begin
            data_wr = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      data_wr = 1'b0;
      chk(n == exp_len, {tag, " R4/R5 busy length"}, n, exp_len);
      chk(strobes == 1, {tag, " R6 strobe count"}, strobes, 1);
      chk(seen_tx == ((late != 0) ? tx2 : tx), {tag, " R6 tx byte"}, seen_tx,
          (late != 0) ? tx2 : tx);
      chk(seen_cmd == exp_cmd, {tag, " R7 command flag"}, seen_cmd, exp_cmd);
      chk(data_rdata == rx, {tag, " R6 rx captured"}, data_rdata, rx);
   endtask

   task automatic t_reset();
      chk(ctl_rdata == '0, "R1 ctl reset", ctl_rdata, 0);
      chk(data_rdata == '0, "R1 data reset", data_rdata, 0);
      chk(slv_sel == 1'b0, "R1 sel reset", slv_sel, 0);
      chk(slv_strobe == 1'b0, "R1 strobe reset", slv_strobe, 0);
   endtask

   task automatic t_gate();
      wr_ctl(MODE);
      wr_data(8'hA1);
      chk(ctl_rdata[3] == 1'b0, "R2 no busy without enable", ctl_rdata[3], 0);
      chk(data_rdata == 8'h00, "R2 data kept without enable", data_rdata, 0);
      wr_ctl(EN);
      wr_data(8'hA2);
      chk(ctl_rdata[3] == 1'b0, "R2 no busy without mode", ctl_rdata[3], 0);
      chk(data_rdata == 8'h00, "R2 data kept without mode", data_rdata, 0);
   endtask

   task automatic t_readback();
      wr_ctl(EN | MODE | BUSY | 6'h2);
      chk(ctl_rdata == (EN | MODE | 6'h2), "R10 busy bit write ignored", ctl_rdata,
          EN | MODE | 6'h2);
      wr_ctl(6'h3F);
      chk(ctl_rdata == (EN | MODE | HOLD | 6'h3), "R10 field readback", ctl_rdata,
          EN | MODE | HOLD | 6'h3);
      wr_ctl(EN | MODE);
      chk(ctl_rdata == (EN | MODE), "R10 readback idle", ctl_rdata, EN | MODE);
   endtask

   task automatic t_basic();
      // hold state is now 0; this mode write reopens framing
      wr_ctl(EN | MODE);
      xfer(8'h9F, 8'h00, 0, 8'h5A, 8, 1'b1, "basic-first");
      xfer(8'h11, 8'h00, 0, 8'hC3, 8, 1'b0, "basic-second");
      chk(ctl_rdata == (EN | MODE), "R10 busy cleared in readback", ctl_rdata, EN | MODE);
   endtask

   task automatic t_rates();
      wr_ctl(EN | MODE | 6'h1);
      xfer(8'h21, 8'h00, 0, 8'h01, 16, 1'b1, "rate1");
      wr_ctl(EN | MODE | 6'h2);
      xfer(8'h22, 8'h00, 0, 8'h02, 32, 1'b1, "rate2");
      wr_ctl(EN | MODE | 6'h3);
      xfer(8'h23, 8'h00, 0, 8'h03, 64, 1'b1, "rate3");
   endtask

   task automatic t_restart();
      wr_ctl(EN | MODE);
      xfer(8'h44, 8'h55, 4, 8'h66, 13, 1'b1, "restart");
   endtask

   task automatic t_hold();
      wr_ctl(EN | MODE | HOLD);
      chk(slv_sel == 1'b1, "R9 sel follows hold", slv_sel, 1);
      xfer(8'h03, 8'h00, 0, 8'h70, 8, 1'b1, "hold-cmd");
      wr_ctl(EN | MODE | HOLD);
      xfer(8'h12, 8'h00, 0, 8'h71, 8, 1'b0, "hold-kept R8");
      wr_ctl(EN);
      chk(slv_sel == 1'b1, "R9 non-mode write keeps hold", slv_sel, 1);
      wr_ctl(EN | MODE);
      chk(slv_sel == 1'b0, "R9 mode write drops hold", slv_sel, 0);
      xfer(8'h13, 8'h00, 0, 8'h72, 8, 1'b0, "hold-release R8");
      wr_ctl(EN | MODE);
      xfer(8'h05, 8'h00, 0, 8'h73, 8, 1'b1, "reopen R8");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gate();
      t_readback();
      t_basic();
      t_rates();
      t_restart();
      t_hold();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule